// File: doc/BRIEF.md
# Digit-Serial by Parallel Two's Complement Multiplier

This block multiplies a signed coefficient, presented in parallel, by a signed data word that arrives a few bits at a time, least significant digit first. The word is W bits wide and each clock carries one N-bit digit, where N divides W. One word therefore takes P = W/N cycles. A shift-and-add array keeps its running partial product as a sum vector and a carry vector. Each cycle it retires the lowest N bits into a small serial adder, which resolves them into one output digit.

The caller raises `sign_last` together with the final digit of a word, which is the digit that holds the data sign bit. In that cycle the coefficient row for the data's top bit is bit-inverted. The data sign bit is registered and added in the following cycle by the serial adder, which completes the negation. The upper half of the product is still held in carry-save form after the sign digit. To release it, the caller feeds P zero digits. At the end of those zero digits the block clears its accumulator and the adder carry on its own, so the next word can follow at once.

The 2W-bit product leaves on `dout`, least significant digit first, over 2P cycles. The first product digit is visible two clock cycles after the cycle in which the first data digit was presented.

Top module: `digit_serial_mult`

## Requirements
- R1: During and right after a synchronous active-low reset, `dout` is zero, and the accumulator and the adder carry are cleared.
- R2: A word is P = W/N digits, least significant first. `sign_last` high with a digit outside the flush phase marks it as the last digit of the word and starts a flush phase of exactly P cycles.
- R3: For a data digit presented in cycle t, the matching product digit appears on `dout` in cycle t+2. The 2P product digits of a word form the full 2W-bit two's complement product of `coef` and the data word, least significant digit first.
- R4: Negative data words are weighted correctly. The top data bit counts as -2^(W-1), through the inverted coefficient row plus the registered sign bit added one cycle later.
- R5: The most negative operands give exact results. (-2^(W-1)) x (-2^(W-1)) = 2^(2W-2), and (-2^(W-1)) x (2^(W-1)-1) is exact.
- R6: On the last flush cycle the sum and carry state is cleared, so a word that starts on the very next cycle is unaffected by the previous one.
- R7: Zero digits fed while no word is in progress leave the state at zero, so `dout` shows zero outside product windows.
- R8: `sign_last` raised during the flush phase is ignored. The flush still ends P cycles after the real sign digit.
- R9: The same RTL gives correct products for W = 8 with N = 1, 2, 4 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| coef | input | W | Signed coefficient, held stable for the whole word |
| din | input | N | Data digit, least significant first; zero during flush and idle |
| sign_last | input | 1 | High with the last (sign) digit of a word |
| dout | output | N | Product digit, least significant first, two cycles after the input |

## Verification
The bench aims at the sign digit with -128 operands. A design that inverted the whole coefficient, or added the sign bit at the wrong weight, would get every negative-data product wrong and would miss 16384 for -128 x -128. Words run back to back, so a missing clear at the end of the flush would leak carries or sign-extension bits into the next product's low digits. Idle gaps with zero outputs and stray `sign_last` pulses inside the flush check that the control neither restarts nor stalls. The whole suite runs on four instances with N = 1, 2, 4 and 8, where an off-by-one in the flush counter or in the digit alignment shows up as shifted or corrupted high digits.

// File: rtl/dsm_pkg.sv
// Shared types for the digit-serial multiplier.
// Assumes nothing beyond a two-phase word sequence (data, flush).
package dsm_pkg;
    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_FLUSH = 1'b1
    } phase_e;
endpackage

// File: rtl/dsm_ctrl.sv
// Word sequencer: detects the sign digit and then counts P flush cycles.
// Assumes the caller feeds zero digits during the flush; sign_last
// inside the flush is ignored.
module dsm_ctrl #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sign_in,
    output logic sign_act,
    output logic clr
);
    import dsm_pkg::*;

    localparam int P   = W / N;
    localparam int FCW = (P > 1) ? $clog2(P) : 1;

    phase_e         phase;
    logic [FCW-1:0] fcnt;

    assign sign_act = sign_in && (phase == PH_DATA);
    assign clr      = (phase == PH_FLUSH) && (fcnt == FCW'(P - 1));

    // Phase and flush-count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DATA;
            fcnt  <= '0;
        end else if (sign_act) begin
            phase <= PH_FLUSH;
            fcnt  <= '0;
        end else if (clr) begin
            phase <= PH_DATA;
            fcnt  <= '0;
        end else if (phase == PH_FLUSH) begin
            fcnt <= fcnt + FCW'(1);
        end
    end

    // R2
    sign_starts_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sign_act |=> (phase == PH_FLUSH && fcnt == '0));

    // R8
    flush_not_restarted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FLUSH && !clr) |=> (phase == PH_FLUSH && fcnt == $past(fcnt) + FCW'(1)));
endmodule

// File: rtl/dsm_pp_rows.sv
// Partial-product row generator: for each bit of the current digit, forms
// the sign-extended coefficient shifted to that bit's place.
// When neg_top is set, the row for the digit's top bit uses the inverted
// coefficient. Assumes AW >= W + N.
module dsm_pp_rows #(
    parameter int W  = 8,
    parameter int N  = 2,
    parameter int AW = 16
) (
    input  logic [W-1:0]          coef,
    input  logic [N-1:0]          digit,
    input  logic                  neg_top,
    output logic [N-1:0][AW-1:0]  rows
);
    logic [AW-1:0] cext;

    assign cext = {{(AW-W){coef[W-1]}}, coef};

    for (genvar j = 0; j < N; j++) begin : g_row
        logic [AW-1:0] ceff;
        if (j == N - 1) begin : g_top
            assign ceff = neg_top ? ~cext : cext;
        end else begin : g_low
            assign ceff = cext;
        end
        assign rows[j] = digit[j] ? (ceff << j) : '0;
    end
endmodule

// File: rtl/dsm_csa_acc.sv
// Carry-save accumulator: folds N rows into the sum/carry state each cycle,
// retires the low N bits of both vectors, and shifts the state right by N.
// Works modulo 2^AW relative to the current digit, which covers the full
// 2W-bit product. clr empties the state after the last flush digit.
module dsm_csa_acc #(
    parameter int N  = 2,
    parameter int AW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0][AW-1:0]  rows,
    input  logic                  clr,
    output logic [N-1:0]          lo_s,
    output logic [N-1:0]          lo_c
);
    logic [AW-1:0] acc_s, acc_c;
    logic [AW-1:0] ss [0:N];
    logic [AW-1:0] cc [0:N];

    assign ss[0] = acc_s;
    assign cc[0] = acc_c;

    for (genvar j = 0; j < N; j++) begin : g_csa
        assign ss[j+1] = ss[j] ^ cc[j] ^ rows[j];
        assign cc[j+1] = ((ss[j] & cc[j]) | (ss[j] & rows[j]) | (cc[j] & rows[j])) << 1;
    end

    // Capture the retired digit and the shifted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_s <= '0;
            acc_c <= '0;
            lo_s  <= '0;
            lo_c  <= '0;
        end else begin
            lo_s  <= ss[N][N-1:0];
            lo_c  <= cc[N][N-1:0];
            acc_s <= clr ? '0 : (ss[N] >> N);
            acc_c <= clr ? '0 : (cc[N] >> N);
        end
    end

    // R6
    state_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_s == '0 && acc_c == '0));

    // R7
    idle_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_s == '0 && acc_c == '0 && rows == '0) |=> (acc_s == '0 && acc_c == '0 && lo_s == '0 && lo_c == '0));
endmodule

// File: rtl/dsm_serial_add.sv
// Final serial adder: adds the retired sum and carry digits, the registered
// data sign bit (weight 2^(N-1) of that digit) and a two-bit running carry.
// Its output is registered. The carry is cleared after the last flush digit.
module dsm_serial_add #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lo_s,
    input  logic [N-1:0] lo_c,
    input  logic         corr_in,
    input  logic         clr_in,
    output logic [N-1:0] dout
);
    localparam logic [N+1:0] CORR_W = (N+2)'(1) << (N - 1);

    logic         corr_q, clr_q;
    logic [1:0]   carry;
    logic [N+1:0] tot;

    assign tot = {2'b00, lo_s} + {2'b00, lo_c} + (corr_q ? CORR_W : '0) + {{N{1'b0}}, carry};

    // Align sign bit and clear request with the retired digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            corr_q <= corr_in;
            clr_q  <= clr_in;
        end
    end

    // Resolve one output digit and keep the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            carry <= '0;
        end else begin
            dout  <= tot[N-1:0];
            carry <= clr_q ? 2'b00 : tot[N+1:N];
        end
    end

    // R3
    carry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry != 2'b11);
endmodule

// File: rtl/digit_serial_mult.sv
// Digit-serial by parallel signed multiplier, top level.
// Data enters N bits per cycle, least significant digit first; sign_last
// marks the last digit; the caller then feeds P zero digits. The 2W-bit
// product leaves on dout, least significant digit first, two cycles behind.
module digit_serial_mult #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] coef,
    input  logic [N-1:0] din,
    input  logic         sign_last,
    output logic [N-1:0] dout
);
    localparam int AW = 2 * W;

    logic                 sign_act, clr, corr;
    logic [N-1:0][AW-1:0] rows;
    logic [N-1:0]         lo_s, lo_c;

    assign corr = sign_act & din[N-1];

    dsm_ctrl #(.W(W), .N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sign_in(sign_last),
        .sign_act(sign_act), .clr(clr)
    );

    dsm_pp_rows #(.W(W), .N(N), .AW(AW)) u_rows (
        .coef(coef), .digit(din), .neg_top(sign_act), .rows(rows)
    );

    dsm_csa_acc #(.N(N), .AW(AW)) u_acc (
        .clk(clk), .rst_n(rst_n), .rows(rows), .clr(clr),
        .lo_s(lo_s), .lo_c(lo_c)
    );

    dsm_serial_add #(.N(N)) u_sadd (
        .clk(clk), .rst_n(rst_n), .lo_s(lo_s), .lo_c(lo_c),
        .corr_in(corr), .clr_in(clr), .dout(dout)
    );
endmodule

// File: tb/tb_digit_serial_mult.sv
// One lane: drives one multiplier instance and scores its products.
module tb_dsm_lane #(
    parameter int W = 8,
    parameter int N = 2
) (
    input logic clk,
    input logic rst_n
);
    localparam int P  = W / N;
    localparam int P2 = 2 * P;

    logic [W-1:0]   coef = '0;
    logic [N-1:0]   din = '0;
    logic           sign_last = 1'b0;
    logic [N-1:0]   dout;
    logic           mk = 1'b0, mk_d1 = 1'b0, mk_d2 = 1'b0;
    logic [2*W-1:0] got = '0;
    logic [2*W-1:0] exp_q [$];
    string          tag_q [$];
    int             col = 0;
    int             checks = 0;
    int             fails = 0;
    bit             done = 1'b0;
    bit             live = 1'b0;

    digit_serial_mult #(.W(W), .N(N)) dut (
        .clk(clk), .rst_n(rst_n), .coef(coef), .din(din),
        .sign_last(sign_last), .dout(dout)
    );

    // Driver: one word, its flush, then idle zero digits.
    task automatic run_word(input logic [W-1:0] c, input logic [W-1:0] x,
                            input int gap, input bit stray_sign, input string tag);
        logic signed [2*W-1:0] e;
        e = $signed(c) * $signed(x);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            coef      = c;
            din       = x[i*N +: N];
            sign_last = (i == P - 1);
            mk        = (i == 0);
        end
        for (int f = 0; f < P; f++) begin
            @(negedge clk);
            din       = '0;
            mk        = 1'b0;
            sign_last = stray_sign && (f == P / 2);
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            sign_last = 1'b0;
            din       = '0;
            coef      = W'($urandom);
        end
    endtask

    // Delay the word-start marker by the two register stages.
    always @(posedge clk) begin
        mk_d1 <= mk;
        mk_d2 <= mk_d1;
    end

    // Monitor: gather 2P digits per word, compare with the scoreboard.
    always @(negedge clk) begin
        if (live) begin
            if (mk_d2) begin
                got = '0;
                got[N-1:0] = dout;
                col = 1;
            end else if (col > 0) begin
                got[col*N +: N] = dout;
                col = col + 1;
            end else begin
                checks++;
                if (dout !== '0) begin
                    fails++;
                    $display("FAIL R7 N=%0d idle dout actual %h expected 0", N, dout);
                end
            end
            if (col == P2) begin
                col = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3 N=%0d product actual %h expected none", N, got);
                end else begin
                    logic [2*W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (got !== e) begin
                        fails++;
                        $display("FAIL %s R9 N=%0d product actual %h expected %h", t, N, got, e);
                    end
                end
            end
        end
    end

    // Stimulus sequence for this lane.
    initial begin
        wait (rst_n === 1'b1);
        @(negedge clk);
        checks++;
        if (dout !== '0) begin
            fails++;
            $display("FAIL R1 N=%0d reset dout actual %h expected 0", N, dout);
        end
        live = 1'b1;
        run_word(8'h80, 8'h80, 0, 1'b0, "R5");
        run_word(8'h80, 8'h7F, 0, 1'b0, "R5");
        run_word(8'h7F, 8'h80, 2, 1'b0, "R4");
        run_word(8'h00, 8'h5A, 0, 1'b0, "R3");
        run_word(8'hC3, 8'h00, 0, 1'b0, "R3");
        run_word(8'hFF, 8'hFF, 1, 1'b0, "R4");
        run_word(8'h7F, 8'h7F, 0, 1'b0, "R3");
        run_word(8'h01, 8'hFF, 0, 1'b1, "R8");
        run_word(8'h80, 8'h80, 0, 1'b1, "R6");
        run_word(8'h55, 8'hAA, 3, 1'b0, "R2");
        for (int k = 0; k < 40; k++) begin
            run_word(W'($urandom), W'($urandom), (k % 3 == 0) ? 1 : 0,
                     (k % 5 == 0), "R3");
        end
        for (int i = 0; i < P2 + 4; i++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R3 N=%0d pending products actual %0d expected 0", N, exp_q.size());
        end
        done = 1'b1;
    end
endmodule

// Top bench: four lanes with N = 1, 2, 4, 8 sharing one clock and reset.
module tb_digit_serial_mult;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   total_checks;
    int   total_fails;
    bit   timed_out = 1'b0;

    always #5 clk = ~clk;

    tb_dsm_lane #(.W(8), .N(1)) lane_n1 (.clk(clk), .rst_n(rst_n));
    tb_dsm_lane #(.W(8), .N(2)) lane_n2 (.clk(clk), .rst_n(rst_n));
    tb_dsm_lane #(.W(8), .N(4)) lane_n4 (.clk(clk), .rst_n(rst_n));
    tb_dsm_lane #(.W(8), .N(8)) lane_n8 (.clk(clk), .rst_n(rst_n));

    // Reset, then wait for all lanes or the watchdog.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 100000; cyc++) begin
            @(negedge clk);
            if (lane_n1.done && lane_n2.done && lane_n4.done && lane_n8.done) break;
            if (cyc == 99999) timed_out = 1'b1;
        end
        total_checks = lane_n1.checks + lane_n2.checks + lane_n4.checks + lane_n8.checks;
        total_fails  = lane_n1.fails + lane_n2.fails + lane_n4.fails + lane_n8.fails;
        if (timed_out) begin
            total_checks++;
            total_fails++;
            $display("FAIL R3 watchdog actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", total_checks, total_fails);
        $finish;
    end
endmodule